// File: doc/BRIEF.md
# Out-of-Order Tag-Wakeup Scheduler with Reorder Buffer

This block takes decoded arithmetic and load instructions one per cycle, strictly in program order, and lets them finish out of order while retiring them in order. Every accepted instruction is given a reorder-buffer slot whose index serves as its tag. The destination register is renamed to that tag. Each source either is ready at issue or is bound to the tag of its producer. A waiting instruction watches a single shared result bus and starts its fixed-latency execution once its last missing tag has been broadcast.

Finished results compete for the one bus, and the entry closest to the buffer head wins. Retirement leaves from the head, at most one per cycle. The commit port is the only path to the architectural register file. No real arithmetic is performed: each result is a token equal to the instruction's issue sequence number since reset. Issue is held off only when every buffer slot is occupied.

Top module: `ooo_sched`

## Requirements
- R1: When `iss_stall` is low, an instruction presented with `iss_valid` high is accepted at that clock edge. At most one is accepted per cycle, in program order. Opcode encoding: 0 add, 1 subtract, 2 multiply, 3 divide, 4 load; codes 5 to 7 behave as add.
- R2: Execution occupies a fixed number of cycles by class: add and subtract 2, multiply 6, divide 12, load 4.
- R3: A result is broadcast in the cycle after its last execute cycle. An instruction whose sources are all ready at issue executes from the next cycle. A waiting instruction starts execution in the cycle after its last missing source tag is broadcast, and this includes a broadcast in its own issue cycle.
- R4: At most one result is broadcast per cycle. When several are ready, the one oldest in program order wins and the rest wait.
- R5: Each destination receives a fresh tag at issue. Later readers bind to that tag, so write-after-read and write-after-write conflicts never delay execution.
- R6: Commit is in program order, at most one per cycle, and no earlier than the cycle after the result's broadcast. The commit port presents `cmt_dst` and `cmt_val`, where `cmt_val` is the instruction's issue sequence number counted from 0 after reset.
- R7: An instruction that finishes early stays in the buffer until every older instruction has committed.
- R8: The buffer holds 8 instructions. `iss_stall` is high exactly while all 8 are occupied, and no instruction is accepted while it is high.
- R9: A register's rename mapping is released at commit only when it still names the committing tag. A reader issued after an older writer commits, while a younger writer of the same register is pending, still waits for the younger writer.
- R10: After reset no commit is presented and `iss_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_op | input | 3 | Operation class code |
| iss_dst | input | 4 | Destination architectural register |
| iss_src_a | input | 4 | First source architectural register |
| iss_src_b | input | 4 | Second source architectural register |
| iss_stall | output | 1 | Buffer full; issue is not accepted |
| cmt_valid | output | 1 | Head instruction commits this cycle |
| cmt_tag | output | 3 | Buffer tag of the committing instruction |
| cmt_dst | output | 4 | Architectural register being written |
| cmt_val | output | 8 | Result token being written |

## Verification
Corrupt internal state shows up in the commit stream. A lost wakeup or a wrongly released rename mapping moves every later commit by a fixed number of cycles. A lost wakeup can also stop commits altogether. A wrong arbitration choice delays a dependent instruction by one cycle and shifts its commit. Mis-tracked occupancy moves the cycle in which a held-off issue is finally accepted. Each of these becomes visible within one execution latency plus one commit slot of its cause.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    OPC_ADD = 3'd0,
    OPC_SUB = 3'd1,
    OPC_MUL = 3'd2,
    OPC_DIV = 3'd3,
    OPC_LD  = 3'd4
  } opc_e;

  typedef enum logic [2:0] {
    SL_FREE = 3'd0,
    SL_WAIT = 3'd1,
    SL_EXEC = 3'd2,
    SL_RDY  = 3'd3,
    SL_DONE = 3'd4
  } slot_st_e;

endpackage

// File: rtl/sched_rename.sv
module sched_rename #(
  parameter int NREG  = 16,
  parameter int REG_W = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd_a_reg,
  output logic             rd_a_busy,
  output logic [TAG_W-1:0] rd_a_tag,
  input  logic [REG_W-1:0] rd_b_reg,
  output logic             rd_b_busy,
  output logic [TAG_W-1:0] rd_b_tag,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [TAG_W-1:0] clr_tag
);

  logic             busy_q [NREG];
  logic [TAG_W-1:0] tag_q  [NREG];
  logic             busy_d [NREG];
  logic [TAG_W-1:0] tag_d  [NREG];

  assign rd_a_busy = busy_q[rd_a_reg];
  assign rd_a_tag  = tag_q[rd_a_reg];
  assign rd_b_busy = busy_q[rd_b_reg];
  assign rd_b_tag  = tag_q[rd_b_reg];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      busy_d[r] = busy_q[r];
      tag_d[r]  = tag_q[r];
    end
    // release only if the mapping still names the retiring tag
    if (clr_en && busy_q[clr_reg] && (tag_q[clr_reg] == clr_tag))
      busy_d[clr_reg] = 1'b0;
    // a new mapping in the same cycle takes precedence
    if (wr_en) begin
      busy_d[wr_reg] = 1'b1;
      tag_d[wr_reg]  = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        busy_q[r] <= busy_d[r];
        tag_q[r]  <= tag_d[r];
      end
    end
  end

endmodule

// File: rtl/sched_bus_arb.sv
module sched_bus_arb #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input  logic [DEPTH-1:0] want,
  input  logic [TAG_W-1:0] head,
  output logic [DEPTH-1:0] grant,
  output logic             bus_v,
  output logic [TAG_W-1:0] bus_tag
);

  logic [TAG_W-1:0] idx;

  // scan from the head so the oldest requester wins
  always_comb begin
    bus_v   = 1'b0;
    bus_tag = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + TAG_W'(k);
      if (!bus_v && want[idx]) begin
        bus_v   = 1'b1;
        bus_tag = idx;
      end
    end
    grant = '0;
    if (bus_v) grant[bus_tag] = 1'b1;
  end

endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int TAG_W = 3,
  parameter int REG_W = 4,
  parameter int VAL_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [CNT_W-1:0] alloc_lat,
  input  logic [REG_W-1:0] alloc_dst,
  input  logic [VAL_W-1:0] alloc_val,
  input  logic             alloc_pa,
  input  logic [TAG_W-1:0] alloc_ta,
  input  logic             alloc_pb,
  input  logic [TAG_W-1:0] alloc_tb,
  input  logic             bus_v,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic             grant,
  input  logic             retire,
  output logic             want_bus,
  output logic             done,
  output logic [REG_W-1:0] dst,
  output logic [VAL_W-1:0] val
);

  slot_st_e         st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             pa_q, pa_d, pb_q, pb_d;
  logic [TAG_W-1:0] ta_q, ta_d, tb_q, tb_d;
  logic [REG_W-1:0] dst_q, dst_d;
  logic [VAL_W-1:0] val_q, val_d;
  logic             wa, wb;

  assign want_bus = (st_q == SL_RDY);
  assign done     = (st_q == SL_DONE);
  assign dst      = dst_q;
  assign val      = val_q;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    pa_d  = pa_q;
    pb_d  = pb_q;
    ta_d  = ta_q;
    tb_d  = tb_q;
    dst_d = dst_q;
    val_d = val_q;
    wa    = pa_q && !(bus_v && (bus_tag == ta_q));
    wb    = pb_q && !(bus_v && (bus_tag == tb_q));
    case (st_q)
      SL_FREE: if (alloc) begin
        dst_d = alloc_dst;
        val_d = alloc_val;
        ta_d  = alloc_ta;
        tb_d  = alloc_tb;
        pa_d  = alloc_pa;
        pb_d  = alloc_pb;
        rem_d = alloc_lat;
        st_d  = (alloc_pa || alloc_pb) ? SL_WAIT : SL_EXEC;
      end
      SL_WAIT: begin
        pa_d = wa;
        pb_d = wb;
        if (!wa && !wb) st_d = SL_EXEC;
      end
      SL_EXEC: begin
        if (rem_q <= CNT_W'(1)) st_d = SL_RDY;
        else                    rem_d = rem_q - CNT_W'(1);
      end
      SL_RDY:  if (grant)  st_d = SL_DONE;
      SL_DONE: if (retire) st_d = SL_FREE;
      default: st_d = SL_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SL_FREE;
      rem_q <= '0;
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      ta_q  <= '0;
      tb_q  <= '0;
      dst_q <= '0;
      val_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      ta_q  <= ta_d;
      tb_q  <= tb_d;
      dst_q <= dst_d;
      val_q <= val_d;
    end
  end

endmodule

// File: rtl/ooo_sched.sv
module ooo_sched
  import sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NREG    = 16,
  parameter int VAL_W   = 8,
  parameter int CNT_W   = 4,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 6,
  parameter int LAT_DIV = 12,
  parameter int LAT_LD  = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [2:0]       iss_op,
  input  logic [REG_W-1:0] iss_dst,
  input  logic [REG_W-1:0] iss_src_a,
  input  logic [REG_W-1:0] iss_src_b,
  output logic             iss_stall,
  output logic             cmt_valid,
  output logic [TAG_W-1:0] cmt_tag,
  output logic [REG_W-1:0] cmt_dst,
  output logic [VAL_W-1:0] cmt_val
);

  // DEPTH must be a power of two so the pointers wrap naturally
  logic [TAG_W:0]   cnt_q, cnt_d;
  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [VAL_W-1:0] seq_q, seq_d;

  logic             iss_fire;
  logic [CNT_W-1:0] iss_lat;
  logic             a_busy, b_busy, a_pend, b_pend;
  logic [TAG_W-1:0] a_tag, b_tag;

  logic [DEPTH-1:0] want_v, grant_v, done_v;
  logic [REG_W-1:0] slot_dst [DEPTH];
  logic [VAL_W-1:0] slot_val [DEPTH];
  logic             bus_v;
  logic [TAG_W-1:0] bus_tag;

  always_comb begin
    case (opc_e'(iss_op))
      OPC_MUL: iss_lat = CNT_W'(LAT_MUL);
      OPC_DIV: iss_lat = CNT_W'(LAT_DIV);
      OPC_LD:  iss_lat = CNT_W'(LAT_LD);
      default: iss_lat = CNT_W'(LAT_ADD);
    endcase
  end

  assign iss_stall = (cnt_q == (TAG_W+1)'(DEPTH));
  assign iss_fire  = iss_valid && !iss_stall;
  assign cmt_valid = done_v[head_q];
  assign cmt_tag   = head_q;
  assign cmt_dst   = slot_dst[head_q];
  assign cmt_val   = slot_val[head_q];

  // a source is still missing unless its producer is done or broadcasting now
  assign a_pend = a_busy && !done_v[a_tag] && !(bus_v && (bus_tag == a_tag));
  assign b_pend = b_busy && !done_v[b_tag] && !(bus_v && (bus_tag == b_tag));

  sched_rename #(.NREG(NREG), .REG_W(REG_W), .TAG_W(TAG_W)) u_rename (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_reg  (iss_src_a),
    .rd_a_busy (a_busy),
    .rd_a_tag  (a_tag),
    .rd_b_reg  (iss_src_b),
    .rd_b_busy (b_busy),
    .rd_b_tag  (b_tag),
    .wr_en     (iss_fire),
    .wr_reg    (iss_dst),
    .wr_tag    (tail_q),
    .clr_en    (cmt_valid),
    .clr_reg   (cmt_dst),
    .clr_tag   (head_q)
  );

  sched_bus_arb #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_arb (
    .want    (want_v),
    .head    (head_q),
    .grant   (grant_v),
    .bus_v   (bus_v),
    .bus_tag (bus_tag)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    sched_slot #(.TAG_W(TAG_W), .REG_W(REG_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (iss_fire && (tail_q == TAG_W'(i))),
      .alloc_lat (iss_lat),
      .alloc_dst (iss_dst),
      .alloc_val (seq_q),
      .alloc_pa  (a_pend),
      .alloc_ta  (a_tag),
      .alloc_pb  (b_pend),
      .alloc_tb  (b_tag),
      .bus_v     (bus_v),
      .bus_tag   (bus_tag),
      .grant     (grant_v[i]),
      .retire    (cmt_valid && (head_q == TAG_W'(i))),
      .want_bus  (want_v[i]),
      .done      (done_v[i]),
      .dst       (slot_dst[i]),
      .val       (slot_val[i])
    );
  end

  always_comb begin
    cnt_d  = cnt_q;
    head_d = head_q;
    tail_d = tail_q;
    seq_d  = seq_q;
    if (iss_fire) begin
      tail_d = tail_q + TAG_W'(1);
      seq_d  = seq_q + VAL_W'(1);
    end
    if (cmt_valid) head_d = head_q + TAG_W'(1);
    case ({iss_fire, cmt_valid})
      2'b10:   cnt_d = cnt_q + (TAG_W+1)'(1);
      2'b01:   cnt_d = cnt_q - (TAG_W+1)'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      seq_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      head_q <= head_d;
      tail_q <= tail_d;
      seq_q  <= seq_d;
    end
  end

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] cmt_tag,
  input logic             iss_stall,
  input logic [DEPTH-1:0] grant,
  input logic [TAG_W:0]   cnt,
  input logic [TAG_W-1:0] head,
  input logic [TAG_W-1:0] tail
);

  p_one_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_inorder_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && $past(cmt_valid)) |-> (cmt_tag == $past(cmt_tag) + TAG_W'(1)));

  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |=> $stable(head));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (TAG_W+1)'(DEPTH));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |=> $stable(tail));

endmodule

bind ooo_sched sched_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmt_valid (cmt_valid),
  .cmt_tag   (cmt_tag),
  .iss_stall (iss_stall),
  .grant     (grant_v),
  .cnt       (cnt_q),
  .head      (head_q),
  .tail      (tail_q)
);

// File: tb/ooo_sched_tb.sv
`timescale 1ns/1ps
module ooo_sched_tb;

  typedef struct {
    int    cyc;
    int    dst;
    int    val;
    string req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       iss_valid;
  logic [2:0] iss_op;
  logic [3:0] iss_dst, iss_src_a, iss_src_b;
  logic       iss_stall, cmt_valid;
  logic [2:0] cmt_tag;
  logic [3:0] cmt_dst;
  logic [7:0] cmt_val;

  exp_t q[$];
  int   cyc = 0;
  int   base = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  ooo_sched u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_stall(iss_stall), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .cmt_dst(cmt_dst), .cmt_val(cmt_val)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc++;

  // monitor: pop and compare every commit
  always @(negedge clk) begin
    exp_t e;
    int   rel;
    if (rst_n && cmt_valid) begin
      rel = cyc - base + 1;
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected commit: actual cycle %0d dst %0d val %0d expected none",
                 rel, cmt_dst, cmt_val);
      end else begin
        e = q.pop_front();
        if (rel != e.cyc || int'(cmt_dst) != e.dst || int'(cmt_val) != e.val) begin
          n_fail++;
          $display("FAIL %s commit: actual cycle %0d dst %0d val %0d expected cycle %0d dst %0d val %0d",
                   e.req, rel, cmt_dst, cmt_val, e.cyc, e.dst, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    iss_valid = 1'b0;
    iss_op = '0; iss_dst = '0; iss_src_a = '0; iss_src_b = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R10 stall after reset", int'(iss_stall), 0);
    check("R10 commit after reset", int'(cmt_valid), 0);
  endtask

  task automatic start();
    @(negedge clk);
    base = cyc + 1;
    q.delete();
  endtask

  task automatic want(input int c, input int d, input int v, input string r);
    exp_t e;
    e.cyc = c; e.dst = d; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic iss(input int k, input int op, input int d, input int a, input int b,
                     output int acc);
    @(negedge clk);
    while (cyc < base + k - 1) @(negedge clk);
    iss_valid = 1'b1;
    iss_op    = 3'(op);
    iss_dst   = 4'(d);
    iss_src_a = 4'(a);
    iss_src_b = 4'(b);
    while (iss_stall) @(negedge clk);
    acc = cyc - base + 1;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 80 && q.size() != 0; i++) @(negedge clk);
    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s missing commit: actual none expected cycle %0d val %0d", e.req, e.cyc, e.val);
    end
  endtask

  initial begin
    int acc;
    // scenario 1: divide chain with false dependences (R2 R3 R5 R6 R7)
    do_reset();
    start();
    want(15, 0, 0, "R2 divide");
    want(18, 6, 1, "R3 add after divide");
    want(25, 10, 2, "R2 multiply");
    want(26, 6, 3, "R7 early subtract");
    want(27, 8, 4, "R5 load despite WAR");
    iss(1, 3, 0, 2, 4, acc);
    iss(2, 0, 6, 0, 8, acc);
    iss(3, 2, 10, 6, 0, acc);
    iss(4, 1, 6, 12, 14, acc);
    iss(5, 4, 8, 1, 1, acc);
    drain();

    // scenario 2: two results ready together, oldest wins (R4)
    do_reset();
    start();
    want(9, 1, 0, "R4 multiply");
    want(10, 4, 1, "R4 add");
    want(13, 5, 2, "R4 dependent of loser");
    iss(1, 2, 1, 2, 3, acc);
    iss(5, 0, 4, 2, 3, acc);
    iss(6, 1, 5, 4, 2, acc);
    drain();

    // scenario 3: buffer fills behind a divide (R8 R1)
    do_reset();
    start();
    want(15, 0, 0, "R8 divide");
    for (int i = 1; i <= 7; i++) want(15 + i, i, i, "R7 held add");
    want(23, 8, 8, "R8 stalled add");
    iss(1, 3, 0, 9, 10, acc);
    for (int i = 1; i <= 7; i++) begin
      iss(i + 1, 0, i, 9, 10, acc);
      check("R1 accept cycle", acc, i + 1);
    end
    iss(9, 0, 8, 9, 10, acc);
    check("R8 stalled issue accept cycle", acc, 16);
    drain();

    // scenario 4: older writer commits while younger writer pending (R9)
    do_reset();
    start();
    want(5, 1, 0, "R9 first writer");
    want(16, 1, 1, "R9 second writer");
    want(19, 2, 2, "R9 reader waits younger");
    iss(1, 0, 1, 8, 9, acc);
    iss(2, 3, 1, 8, 9, acc);
    iss(10, 0, 2, 1, 0, acc);
    drain();

    // scenario 5: source broadcast in the reader's issue cycle (R3)
    do_reset();
    start();
    want(5, 3, 0, "R3 producer");
    want(8, 4, 1, "R3 same-cycle wakeup");
    iss(1, 0, 3, 8, 9, acc);
    iss(4, 0, 4, 3, 5, acc);
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule